// File: doc/BRIEF.md
# Serial Hold Pause Controller

This block lets a serial memory slave pause a transaction part way through a byte. An active-low pause input is watched together with the serial clock and the active-low select. When the pause input goes low while the serial clock is low, the block raises a hold flag. If the serial clock is high at that moment, the flag is raised at the start of the next clock-low phase. Release follows the same rule. While the flag is up, the serial output enable is withdrawn, and clock edges are neither passed on nor counted. The bit position inside the current unit is therefore kept, and the transfer continues at the same bit after release.

The three pins are brought into the local clock domain through a synchronizer of selectable depth. The block then gives the command decoder gated rising and falling data-clock strobes, the current bit index within a unit, the hold flag, and the output enable. The decoder freezes its shift registers whenever the strobes are absent. A high select clears everything. After a high select, communication can only resume through a fresh select fall with the pause input high. Both idle-low (mode 0) and idle-high (mode 3) clocking are handled, and in both cases the clock-low level is the condition for a hold change.

Top module: `spi_hold_ctrl`

## Requirements
- R1: After reset, hold_active_o is 0, so_oe_o is 0 and bit_pos_o is 0.
- R2: With cs_n_i low and sck_i low, a low hold_n_i sets hold_active_o.
- R3: If hold_n_i falls while sck_i is high, hold_active_o stays 0 until sck_i next goes low, and is then set.
- R4: Hold is released only while sck_i is low. A hold_n_i rise during a high sck_i takes effect at the next low sck_i.
- R5: so_oe_o is 1 only while cs_n_i is low and hold_active_o is 0.
- R6: While hold_active_o is 1, no data_rise_o or data_fall_o strobe occurs and bit_pos_o does not change, so the bit index is the same after release as before the hold.
- R7: A high cs_n_i clears hold_active_o and bit_pos_o. A following cs_n_i fall with hold_n_i still low and sck_i low re-enters hold instead of resuming.
- R8: Each rising sck_i edge seen with cs_n_i low and no hold gives one data_rise_o strobe and advances bit_pos_o by one. bit_pos_o returns from BITS_PER_UNIT-1 to 0.
- R9: A falling sck_i edge gives a data_fall_o strobe only if cs_n_i is low and hold was not active before the edge. A cs_n_i fall while sck_i is already high (mode 3 idle) counts as no rising edge.
- R10: A pin change shows on hold_active_o after SYNC_STAGES+1 rising clk edges, and not after SYNC_STAGES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock pin |
| cs_n_i | input | 1 | Active-low select pin |
| hold_n_i | input | 1 | Active-low pause pin |
| hold_active_o | output | 1 | Pause in effect |
| so_oe_o | output | 1 | Serial output enable; 0 means high impedance |
| data_rise_o | output | 1 | One-cycle strobe for an accepted rising serial clock edge |
| data_fall_o | output | 1 | One-cycle strobe for an accepted falling serial clock edge |
| bit_pos_o | output | POS_W | Bit index within the current unit |

## Verification
The bench builds the block with SYNC_STAGES=2 and BITS_PER_UNIT=4. The short unit makes the bit index wrap inside a few clock pulses, so the test can show a wrap with a hold placed just before it. The two-stage synchronizer gives a fixed three-edge latency, which the bench measures edge by edge. The table walks both clock idle levels. It places pause changes in the high phase and in the low phase of the serial clock, and includes select release during a hold.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;

  typedef struct packed {
    logic sck;
    logic cs_n;
    logic hold_n;
  } pins_t;

  localparam pins_t PINS_IDLE = '{sck: 1'b0, cs_n: 1'b1, hold_n: 1'b1};

  // Next hold state: changes only during the clock-low phase, cleared by deselect.
  function automatic logic hold_next(input logic cs_n, input logic sck,
                                     input logic hold_n, input logic held);
    if (cs_n)
      return 1'b0;
    if (!sck)
      return !hold_n;
    return held;
  endfunction

  // Bit index advance with wrap at the unit length.
  function automatic int unsigned pos_next(input int unsigned pos,
                                           input int unsigned units);
    if (pos + 1 >= units)
      return 0;
    return pos + 1;
  endfunction

endpackage

// File: rtl/spi_hold_sync.sv
module spi_hold_sync
  import spi_hold_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  pins_t raw_i,
  output pins_t sync_o
);

  pins_t pipe [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          pipe[g] <= PINS_IDLE;
        else if (g == 0)
          pipe[g] <= raw_i;
        else
          pipe[g] <= pipe[(g == 0) ? 0 : g - 1];
      end
    end
  endgenerate

  assign sync_o = pipe[STAGES-1];

endmodule

// File: rtl/spi_hold_tracker.sv
module spi_hold_tracker
  import spi_hold_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  pins_t pins_i,
  output logic  held_o
);

  logic held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      held_q <= 1'b0;
    else
      held_q <= hold_next(pins_i.cs_n, pins_i.sck, pins_i.hold_n, held_q);
  end

  assign held_o = held_q;

endmodule

// File: rtl/spi_hold_edge_gate.sv
module spi_hold_edge_gate
  import spi_hold_pkg::*;
#(
  parameter int BITS_PER_UNIT = 8,
  localparam int POS_W = (BITS_PER_UNIT > 1) ? $clog2(BITS_PER_UNIT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pins_t            pins_i,
  input  logic             held_i,
  output logic             rise_o,
  output logic             fall_o,
  output logic [POS_W-1:0] pos_o
);

  logic             sck_d;
  logic [POS_W-1:0] pos_q;
  logic             open_win;

  assign open_win = !pins_i.cs_n && !held_i;
  assign rise_o   = open_win &&  pins_i.sck && !sck_d;
  assign fall_o   = open_win && !pins_i.sck &&  sck_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      pos_q <= '0;
    end else begin
      sck_d <= pins_i.sck;
      if (pins_i.cs_n)
        pos_q <= '0;
      else if (rise_o)
        pos_q <= POS_W'(pos_next(int'(pos_q), BITS_PER_UNIT));
    end
  end

  assign pos_o = pos_q;

endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl
  import spi_hold_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int BITS_PER_UNIT = 8,
  localparam int POS_W = (BITS_PER_UNIT > 1) ? $clog2(BITS_PER_UNIT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck_i,
  input  logic             cs_n_i,
  input  logic             hold_n_i,
  output logic             hold_active_o,
  output logic             so_oe_o,
  output logic             data_rise_o,
  output logic             data_fall_o,
  output logic [POS_W-1:0] bit_pos_o
);

  pins_t pins_raw;
  pins_t pins_s;
  logic  held;

  assign pins_raw = '{sck: sck_i, cs_n: cs_n_i, hold_n: hold_n_i};

  spi_hold_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  (pins_raw),
    .sync_o (pins_s)
  );

  spi_hold_tracker u_track (
    .clk    (clk),
    .rst_n  (rst_n),
    .pins_i (pins_s),
    .held_o (held)
  );

  spi_hold_edge_gate #(.BITS_PER_UNIT(BITS_PER_UNIT)) u_gate (
    .clk    (clk),
    .rst_n  (rst_n),
    .pins_i (pins_s),
    .held_i (held),
    .rise_o (data_rise_o),
    .fall_o (data_fall_o),
    .pos_o  (bit_pos_o)
  );

  assign hold_active_o = held;
  assign so_oe_o       = !pins_s.cs_n && !held;

endmodule

// File: rtl/spi_hold_ctrl_chk.sv
module spi_hold_ctrl_chk #(
  parameter int POS_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             s_sck,
  input logic             s_cs_n,
  input logic             hold_active,
  input logic             so_oe,
  input logic             data_rise,
  input logic             data_fall,
  input logic [POS_W-1:0] bit_pos
);

  p_oe_off_in_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hold_active |-> !so_oe);

  p_change_on_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_active != $past(hold_active)) && !$past(s_cs_n) |-> !$past(s_sck));

  p_no_strobe_in_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hold_active |-> !data_rise && !data_fall);

  p_pos_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hold_active |=> $stable(bit_pos));

  p_deselect_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    s_cs_n |=> !hold_active && (bit_pos == '0));

  p_one_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_rise && data_fall));

  p_pos_needs_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !data_rise && !s_cs_n |=> $stable(bit_pos));

endmodule

bind spi_hold_ctrl spi_hold_ctrl_chk #(.POS_W(POS_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .s_sck       (pins_s.sck),
  .s_cs_n      (pins_s.cs_n),
  .hold_active (hold_active_o),
  .so_oe       (so_oe_o),
  .data_rise   (data_rise_o),
  .data_fall   (data_fall_o),
  .bit_pos     (bit_pos_o)
);

// File: tb/spi_hold_ctrl_bench.sv
module spi_hold_ctrl_bench;

  localparam int SYNC = 2;
  localparam int BITS = 4;
  localparam int PW   = 2;
  localparam int NVEC = 29;

  // {sck, cs_n, hold_n, exp_hold, exp_oe, exp_pos[1:0], exp_fall_inc}
  localparam logic [7:0] VEC [NVEC] = '{
    8'b01100000, 8'b00101000, 8'b10101010, 8'b00101011, 8'b00010010,
    8'b10010010, 8'b00010010, 8'b10010010, 8'b10110010, 8'b00101010,
    8'b10101100, 8'b10001100, 8'b00010101, 8'b00101100, 8'b10101110,
    8'b00101111, 8'b10101000, 8'b00010001, 8'b01000000, 8'b00010000,
    8'b01100000, 8'b00101000, 8'b11100000, 8'b10101000, 8'b00010001,
    8'b10010000, 8'b10110000, 8'b00101000, 8'b10101010
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sck = 1'b0, cs_n = 1'b1, hold_n = 1'b1;
  logic          hold_active, so_oe, data_rise, data_fall;
  logic [PW-1:0] bit_pos;
  int            checks = 0, failures = 0, fall_cnt = 0;
  bit            done = 1'b0;

  always #5 clk = ~clk;

  spi_hold_ctrl #(.SYNC_STAGES(SYNC), .BITS_PER_UNIT(BITS)) u_spi_hold_ctrl (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .cs_n_i(cs_n), .hold_n_i(hold_n),
    .hold_active_o(hold_active), .so_oe_o(so_oe), .data_rise_o(data_rise),
    .data_fall_o(data_fall), .bit_pos_o(bit_pos)
  );

  always @(posedge clk) if (rst_n && data_fall) fall_cnt++;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 hold after reset", int'(hold_active), 0);
    check("R1 oe after reset", int'(so_oe), 0);
    check("R1 pos after reset", int'(bit_pos), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      int f0;
      @(negedge clk);
      sck = VEC[i][7]; cs_n = VEC[i][6]; hold_n = VEC[i][5];
      f0 = fall_cnt;
      repeat (6) @(negedge clk);
      check($sformatf("R2 R3 R4 R7 hold row %0d", i), int'(hold_active), int'(VEC[i][4]));
      check($sformatf("R5 oe row %0d", i), int'(so_oe), int'(VEC[i][3]));
      check($sformatf("R6 R8 pos row %0d", i), int'(bit_pos), int'(VEC[i][2:1]));
      check($sformatf("R9 fall row %0d", i), fall_cnt - f0, int'(VEC[i][0]));
    end

    // R10: latency of a hold entry, measured edge by edge
    @(negedge clk); sck = 1'b0; cs_n = 1'b0; hold_n = 1'b1;
    repeat (6) @(negedge clk);
    hold_n = 1'b0;
    repeat (SYNC) @(negedge clk);
    check("R10 not yet after SYNC edges", int'(hold_active), 0);
    @(negedge clk);
    check("R10 set after SYNC+1 edges", int'(hold_active), 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule